// File: doc/BRIEF.md
# Address Security Attribution Resolver

The resolver classifies every address presented on its lookup port as Secure, Non-secure Callable or Non-secure. Software programs a small set of address windows through a synchronous register port: a global enable, a read-only capacity register, a window selector, and a base and a limit register for each window. A window marks its matching addresses either Non-secure or Non-secure Callable. Any address that no window claims stays Secure, and so does any address claimed by more than one window.

Each lookup also carries the attribute produced by a second, implementation-specific attribution source. The block merges the two and the more privileged one wins: Secure ranks above Non-secure Callable, which ranks above Non-secure. The lookup path is purely combinational from the address over registered configuration. A register write therefore changes the result from the cycle after the write.

Top module: `mem_attr_resolver`

## Requirements
- R1: After reset every register reads zero except the capacity register, reg_rdata is zero, and attr_out is Secure (2'b10) for any address when ext_attr is not higher.
- R2: Register word 0, bit 0 is the global enable. While it is clear, attr_out is Secure for every address.
- R3: While enabled with no window enabled, attr_out is Secure for every address.
- R4: Register word 1 is read-only and returns NUM_REGIONS in its low bits. Writes to it have no effect.
- R5: Register word 2 selects the window that words 3 (base) and 4 (limit) access. A write of an index at or above NUM_REGIONS is ignored and the previous selection stays.
- R6: An address matches a window when addr[31:5] lies between base[31:5] and limit[31:5] inclusive. Bits [4:0] of base and limit are not stored and read zero, so a limit of 0x1FE0 covers up to and including 0x1FFF.
- R7: In the limit word, bit 0 enables the window and bit 1 selects Non-secure Callable (2'b01) rather than Non-secure (2'b00) for matches. A disabled window matches nothing.
- R8: The result is Secure if either source gives Secure (ext_attr 2'b11 counts as Secure). Otherwise it is Non-secure Callable if either source gives it. Only two Non-secure sources give Non-secure.
- R9: An address matched by two or more enabled windows has a local attribute of Secure.
- R10: A register write changes attr_out from the clock edge that takes it. A read with reg_re returns its data on reg_rdata after the next edge, and reg_rdata holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| lkp_addr | input | 32 | Address to classify |
| ext_attr | input | 2 | Attribute from the second attribution source |
| attr_out | output | 2 | Final merged attribute |

## Verification
Two things can happen in the same cycle: a register write that reconfigures a window or the enable, and a lookup whose answer depends on that configuration. The bench drives a lookup on an address inside a Non-secure window while it raises a write that clears the enable. It checks that the old answer holds before the edge and that the new answer appears right after it. In the same way, the merge of the external attribute with an overlapping-window result is judged in one lookup cycle. The expected values come from a vector table computed from the ordering rule.

// File: rtl/attr_pkg.sv
// Package: attribute encoding and register word indices shared by the
// resolver and its submodules. Assumes a 2-bit ranked attribute code.
package attr_pkg;
    localparam logic [1:0] ATTR_NS  = 2'b00;
    localparam logic [1:0] ATTR_NSC = 2'b01;
    localparam logic [1:0] ATTR_S   = 2'b10;

    localparam logic [2:0] RG_CTRL  = 3'd0;
    localparam logic [2:0] RG_CAP   = 3'd1;
    localparam logic [2:0] RG_SEL   = 3'd2;
    localparam logic [2:0] RG_BASE  = 3'd3;
    localparam logic [2:0] RG_LIMIT = 3'd4;
endpackage

// File: rtl/attr_regfile.sv
// Register file: holds the global enable, the window selector and the
// per-window base/limit/flags. Assumes ADDR_W >= GRAN + 2.
module attr_regfile #(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 32,
    parameter int GRAN        = 5,
    localparam int SEL_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
    localparam int HI_W       = ADDR_W - GRAN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [2:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              ctrl_en,
    output logic [HI_W-1:0]   base_hi [NUM_REGIONS],
    output logic [HI_W-1:0]   lim_hi  [NUM_REGIONS],
    output logic [NUM_REGIONS-1:0] win_en,
    output logic [NUM_REGIONS-1:0] win_nsc
);
    import attr_pkg::*;

    logic [SEL_W-1:0]  sel_q;
    logic [ADDR_W-1:0] rd_mux;

    // Register writes: enable, selector (range-checked) and selected window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            sel_q   <= '0;
            win_en  <= '0;
            win_nsc <= '0;
            for (int i = 0; i < NUM_REGIONS; i++) begin
                base_hi[i] <= '0;
                lim_hi[i]  <= '0;
            end
        end else if (reg_we) begin
            case (reg_addr)
                RG_CTRL:  ctrl_en <= reg_wdata[0];
                RG_SEL:   if (reg_wdata < ADDR_W'(NUM_REGIONS))
                              sel_q <= reg_wdata[SEL_W-1:0];
                RG_BASE:  base_hi[sel_q] <= reg_wdata[ADDR_W-1:GRAN];
                RG_LIMIT: begin
                    lim_hi[sel_q]  <= reg_wdata[ADDR_W-1:GRAN];
                    win_nsc[sel_q] <= reg_wdata[1];
                    win_en[sel_q]  <= reg_wdata[0];
                end
                default: ;
            endcase
        end
    end

    // Read multiplexer over the register words.
    always_comb begin
        case (reg_addr)
            RG_CTRL:  rd_mux = {{(ADDR_W-1){1'b0}}, ctrl_en};
            RG_CAP:   rd_mux = ADDR_W'(NUM_REGIONS);
            RG_SEL:   rd_mux = ADDR_W'(sel_q);
            RG_BASE:  rd_mux = {base_hi[sel_q], {GRAN{1'b0}}};
            RG_LIMIT: rd_mux = {lim_hi[sel_q], {(GRAN-2){1'b0}},
                                win_nsc[sel_q], win_en[sel_q]};
            default:  rd_mux = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_re) reg_rdata <= rd_mux;
    end
endmodule

// File: rtl/attr_window_match.sv
// Window comparators: one inclusive range compare per window on the
// granule-aligned address bits. Purely combinational.
module attr_window_match #(
    parameter int NUM_REGIONS = 4,
    parameter int HI_W        = 27
) (
    input  logic [HI_W-1:0]        addr_hi,
    input  logic [HI_W-1:0]        base_hi [NUM_REGIONS],
    input  logic [HI_W-1:0]        lim_hi  [NUM_REGIONS],
    input  logic [NUM_REGIONS-1:0] win_en,
    output logic [NUM_REGIONS-1:0] hit
);
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
        // Inclusive window compare, gated by the window enable.
        assign hit[g] = win_en[g] && (addr_hi >= base_hi[g]) && (addr_hi <= lim_hi[g]);
    end
endmodule

// File: rtl/attr_merge.sv
// Attribute merge: derives the local attribute from window hits and
// merges it with the external source, the higher rank winning.
module attr_merge #(
    parameter int NUM_REGIONS = 4
) (
    input  logic                   ctrl_en,
    input  logic [NUM_REGIONS-1:0] hit,
    input  logic [NUM_REGIONS-1:0] win_nsc,
    input  logic [1:0]             ext_attr,
    output logic [1:0]             local_attr,
    output logic [1:0]             final_attr
);
    import attr_pkg::*;

    // Local attribute: Secure unless exactly one enabled window claims it.
    always_comb begin
        if (!ctrl_en || $countones(hit) != 1) local_attr = ATTR_S;
        else if (|(hit & win_nsc))            local_attr = ATTR_NSC;
        else                                  local_attr = ATTR_NS;
    end

    // Rank merge: Secure > Non-secure Callable > Non-secure.
    always_comb begin
        if (local_attr == ATTR_S || ext_attr[1])            final_attr = ATTR_S;
        else if (local_attr == ATTR_NSC || ext_attr == ATTR_NSC) final_attr = ATTR_NSC;
        else                                                final_attr = ATTR_NS;
    end
endmodule

// File: rtl/mem_attr_resolver.sv
// Top: programmable address security attribution with external merge.
// Assumes one register access port and a combinational lookup path.
module mem_attr_resolver #(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 32,
    parameter int GRAN        = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [2:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] lkp_addr,
    input  logic [1:0]        ext_attr,
    output logic [1:0]        attr_out
);
    localparam int HI_W = ADDR_W - GRAN;

    logic                   ctrl_en;
    logic [HI_W-1:0]        base_hi [NUM_REGIONS];
    logic [HI_W-1:0]        lim_hi  [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] win_en;
    logic [NUM_REGIONS-1:0] win_nsc;
    logic [NUM_REGIONS-1:0] hit;
    logic [1:0]             local_attr;

    attr_regfile #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .GRAN(GRAN)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ctrl_en(ctrl_en), .base_hi(base_hi), .lim_hi(lim_hi),
        .win_en(win_en), .win_nsc(win_nsc)
    );

    attr_window_match #(.NUM_REGIONS(NUM_REGIONS), .HI_W(HI_W)) u_match (
        .addr_hi(lkp_addr[ADDR_W-1:GRAN]), .base_hi(base_hi), .lim_hi(lim_hi),
        .win_en(win_en), .hit(hit)
    );

    attr_merge #(.NUM_REGIONS(NUM_REGIONS)) u_merge (
        .ctrl_en(ctrl_en), .hit(hit), .win_nsc(win_nsc), .ext_attr(ext_attr),
        .local_attr(local_attr), .final_attr(attr_out)
    );
endmodule

// File: rtl/mem_attr_resolver_chk.sv
// Checker: temporal properties of the resolver, bound to the top module.
module mem_attr_resolver_chk #(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   reg_we,
    input logic                   reg_re,
    input logic [2:0]             reg_addr,
    input logic [ADDR_W-1:0]      reg_wdata,
    input logic [ADDR_W-1:0]      reg_rdata,
    input logic [1:0]             ext_attr,
    input logic [1:0]             attr_out,
    input logic                   ctrl_en,
    input logic [NUM_REGIONS-1:0] hit,
    input logic [1:0]             local_attr
);
    p_disabled_secure_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> attr_out == 2'b10);

    p_ext_secure_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_attr[1] |-> attr_out == 2'b10);

    p_nsc_not_lowered_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_attr == 2'b01 |-> attr_out != 2'b00);

    p_overlap_secure_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit) > 1 |-> local_attr == 2'b10);

    p_cap_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && reg_addr == 3'd1) |=> reg_rdata == ADDR_W'(NUM_REGIONS));

    p_disable_next_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd0 && !reg_wdata[0]) |=> attr_out == 2'b10);
endmodule

bind mem_attr_resolver mem_attr_resolver_chk #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_attr(ext_attr), .attr_out(attr_out), .ctrl_en(ctrl_en),
    .hit(hit), .local_attr(local_attr)
);

// File: tb/mem_attr_resolver_tb.sv
// Bench: vector table of lookups over a fixed window layout, then
// directed checks for reset, registers and same-cycle write/lookup.
module mem_attr_resolver_tb;
    localparam logic [1:0] NS = 2'b00, NC = 2'b01, SE = 2'b10;
    localparam int NVEC = 14;
    // {address, external attribute, expected result}
    localparam logic [35:0] VEC [NVEC] = '{
        {32'h0000_0FFF, NS, SE},  // R6 below window 0
        {32'h0000_1000, NS, NS},  // R6 base edge
        {32'h0000_1FFF, NS, NS},  // R6 limit 0x1FE0 covers 0x1FFF
        {32'h0000_2000, NS, SE},  // R6 just past limit
        {32'h0000_1800, NC, NC},  // R8 NS + NSC
        {32'h0000_1800, SE, SE},  // R8 external Secure wins
        {32'h0000_4000, NS, NC},  // R7 NSC window
        {32'h0000_5FFF, NS, NC},  // R7 NSC window top
        {32'h0000_5FFF, SE, SE},  // R8
        {32'h0000_5010, NS, SE},  // R9 overlap
        {32'h0000_503F, NS, SE},  // R9 overlap top
        {32'h0000_5040, NS, NC},  // R9 past overlap
        {32'h0000_8800, NS, SE},  // R7 disabled window
        {32'h0000_6000, NC, SE}   // R8 local Secure beats NSC
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] lkp_addr = '0;
    logic [1:0]  ext_attr = '0;
    logic [1:0]  attr_out;
    int          n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    mem_attr_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lkp_addr(lkp_addr), .ext_attr(ext_attr), .attr_out(attr_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); reg_re = 1'b1; reg_addr = a;
        @(negedge clk); reg_re = 1'b0; #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic look(input logic [31:0] a, input logic [1:0] e, input logic [1:0] exp, input string tag);
        @(negedge clk); lkp_addr = a; ext_attr = e; #1;
        check(tag, {30'b0, attr_out}, {30'b0, exp});
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, 32'h0, "R1 ctrl reset");
        look(32'h1000, NS, SE, "R1 reset attr");
        // Program windows while disabled: R2
        wr(3'd2, 0); wr(3'd3, 32'h1000); wr(3'd4, 32'h1FE1);
        look(32'h1000, NS, SE, "R2 disabled");
        // R3 enabled, window 0 temporarily off
        wr(3'd4, 32'h1FE0); wr(3'd0, 1);
        look(32'h1000, NS, SE, "R3 no window enabled");
        wr(3'd4, 32'h1FE1);
        wr(3'd2, 1); wr(3'd3, 32'h4000); wr(3'd4, 32'h5FE3);
        wr(3'd2, 2); wr(3'd3, 32'h5000); wr(3'd4, 32'h5021);
        wr(3'd2, 3); wr(3'd3, 32'h8000); wr(3'd4, 32'h8FE2);
        // Vector walk: R6 R7 R8 R9
        for (int i = 0; i < NVEC; i++)
            look(VEC[i][35:4], VEC[i][3:2], VEC[i][1:0], $sformatf("R6-9 vec %0d", i));
        // R4 capacity read-only
        rd(3'd1, 32'd4, "R4 capacity");
        wr(3'd1, 32'hFF);
        rd(3'd1, 32'd4, "R4 capacity after write");
        // R5 select range
        wr(3'd2, 2); wr(3'd2, 9);
        rd(3'd2, 32'd2, "R5 out-of-range select ignored");
        rd(3'd4, 32'h5021, "R5 limit of selected");
        // R6 low bits ignored
        wr(3'd2, 0); wr(3'd3, 32'h101F);
        rd(3'd3, 32'h1000, "R6 base low bits");
        // R10 write and lookup in the same cycle
        @(negedge clk); lkp_addr = 32'h1800; ext_attr = NS;
        reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 0; #1;
        check("R10 before edge", {30'b0, attr_out}, {30'b0, NS});
        @(negedge clk); reg_we = 1'b0; #1;
        check("R10 after edge", {30'b0, attr_out}, {30'b0, SE});
        rd(3'd0, 32'h0, "R10 ctrl readback");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule